// File: doc/BRIEF.md
# Dual-Line Masked Interrupt Aggregator

This block collects level-sensitive request lines from on-chip peripherals, plus one source that software raises and lowers, and produces two processor request lines: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Each output has its own bank of three views. The raw view follows the sources as they are. The enable mask is changed through separate set and clear registers. The status view is the raw view gated by that bank's mask. A given bit position names the same source in both banks.

Software finds which source caused an interrupt by reading the status register of the bank concerned. The block does no priority encoding, no vector generation and no nesting. Clearing a request is left to the peripheral that raised it. Each output is the registered OR of its bank's status bits. In the fast bank, status bit 0 is a summary flag that is 1 whenever any fast source is active.

Top module: `intc_dual`

## Requirements
- R1: After reset, every status and raw register reads 0, both enable masks read 0, the software request bit is 0, and `irq_o` and `fiq_o` are 0.
- R2: Raw register bits 25..2 follow `per_irq_i[23:0]` as they are, with no latching. Raw bit 0 and bits 31..26 read 0. The raw registers are at offset 0x004 (normal) and 0x104 (fast).
- R3: Writing offset 0x010 loads `wdata_i[1]` into the software request. That request appears as raw bit 1 in both banks, and reading 0x010 returns it in bit 1.
- R4: Normal status (offset 0x000) equals the raw value ANDed with the normal enable mask. Its bit 0 always reads 0.
- R5: Fast status (offset 0x100) bits 25..1 equal the raw value ANDed with the fast enable mask. Bit 0 is 1 exactly when any of bits 25..1 is 1.
- R6: A write to the enable-set register (0x008 normal, 0x108 fast) sets each mask bit whose `wdata_i` bit is 1 and leaves the other bits unchanged. Reading that offset returns the mask. Only bits 25..1 can ever be 1.
- R7: A write to the enable-clear register (0x00C normal, 0x10C fast) clears each mask bit whose `wdata_i` bit is 1 and leaves the other bits unchanged.
- R8: `irq_o` equals, one clock later, the OR of all normal status bits. `fiq_o` equals, one clock later, the OR of all fast status bits.
- R9: The two masks are independent. A source enabled in both banks asserts both outputs, and changing one bank's mask does not alter the other bank.
- R10: Writes to the status and raw offsets have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| per_irq_i | input | 24 | Peripheral request lines, level sensitive, mapped to bits 25..2 |
| addr_i | input | 9 | Register byte offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
Read data is combinational. Raw and status values are therefore due in the same cycle as a source change or a mask update, and the bench reads them a fraction of a nanosecond after it sets the address, in the middle of the cycle. The outputs pass through one register. After a source change driven on a falling edge, the bench lets one rising edge pass and samples the output on the next falling edge. A mask write is committed on the rising edge after it is driven, so the output is checked one full cycle later. Before each step that should raise an output, the bench also confirms the output is still low at the earlier sample point, which catches both a missing register stage and an extra one.

// File: rtl/intc_dual.sv
module intc_dual #(
  parameter int NPER = 24,
  parameter int AW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPER-1:0] per_irq_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam logic [31:0] SRC_MASK = {{(30-NPER){1'b0}}, {(NPER+1){1'b1}}, 1'b0};
  localparam logic [7:0] OFS_STA = 8'h00, OFS_RAW = 8'h04, OFS_SET = 8'h08,
                         OFS_CLR = 8'h0C, OFS_SWI = 8'h10;

  logic        swi_q;
  logic [31:0] irq_en_q, fiq_en_q;
  logic [31:0] raw, irq_sta, fiq_sta, fiq_hit;
  logic        fbank;
  logic [7:0]  ofs;

  assign fbank = addr_i[8];
  assign ofs   = addr_i[7:0];

  assign raw     = {{(30-NPER){1'b0}}, per_irq_i, swi_q, 1'b0};
  assign irq_sta = raw & irq_en_q;
  assign fiq_hit = raw & fiq_en_q;
  assign fiq_sta = {fiq_hit[31:1], |fiq_hit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      swi_q    <= 1'b0;
      irq_en_q <= '0;
      fiq_en_q <= '0;
      irq_o    <= 1'b0;
      fiq_o    <= 1'b0;
    end else begin
      irq_o <= |irq_sta;
      fiq_o <= |fiq_sta;
      if (wr_i) begin
        if (!fbank && ofs == OFS_SWI) swi_q <= wdata_i[1];
        if (!fbank && ofs == OFS_SET) irq_en_q <= irq_en_q | (wdata_i & SRC_MASK);
        if (!fbank && ofs == OFS_CLR) irq_en_q <= irq_en_q & ~wdata_i;
        if ( fbank && ofs == OFS_SET) fiq_en_q <= fiq_en_q | (wdata_i & SRC_MASK);
        if ( fbank && ofs == OFS_CLR) fiq_en_q <= fiq_en_q & ~wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (ofs)
      OFS_STA: rdata_o = fbank ? fiq_sta : irq_sta;
      OFS_RAW: rdata_o = raw;
      OFS_SET: rdata_o = fbank ? fiq_en_q : irq_en_q;
      OFS_SWI: rdata_o = fbank ? 32'h0 : {30'h0, swi_q, 1'b0};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/intc_dual_chk.sv
module intc_dual_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [8:0]  addr_i,
  input logic        wr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] irq_sta,
  input logic [31:0] fiq_sta,
  input logic [31:0] irq_en_q,
  input logic [31:0] fiq_en_q,
  input logic        irq_o,
  input logic        fiq_o
);
  p_irq_b0_r4: assert property (@(posedge clk) disable iff (!rst_n) irq_sta[0] == 1'b0);
  p_fiq_sum_r5: assert property (@(posedge clk) disable iff (!rst_n) fiq_sta[0] == |fiq_sta[31:1]);
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == 9'h008) |=> ((irq_en_q & $past(wdata_i) & 32'h03FF_FFFE) == ($past(wdata_i) & 32'h03FF_FFFE)));
  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i == 9'h10C) |=> ((fiq_en_q & $past(wdata_i)) == 32'h0));
  p_irq_lat_r8: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> irq_o == $past(|irq_sta));
  p_fiq_lat_r8: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> fiq_o == $past(|fiq_sta));
  p_indep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && addr_i[8]) |=> $stable(irq_en_q));
  p_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (addr_i[7:0] == 8'h00 || addr_i[7:0] == 8'h04)) |=> ($stable(irq_en_q) && $stable(fiq_en_q)));
endmodule

bind intc_dual intc_dual_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .wdata_i(wdata_i),
  .irq_sta(irq_sta), .fiq_sta(fiq_sta), .irq_en_q(irq_en_q), .fiq_en_q(fiq_en_q),
  .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/intc_dual_bench.sv
module intc_dual_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] per_irq = '0;
  logic [8:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int n_chk = 0, n_fail = 0;

  intc_dual u_intc_dual (.clk(clk), .rst_n(rst_n), .per_irq_i(per_irq), .addr_i(addr),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
    addr = a; #0.5;
    chk(req, rdata, exp);
  endtask

  task automatic settle; @(negedge clk); endtask

  task automatic t_reset;
    per_irq = 24'hFFFFFF;
    settle();
    rd_chk("R1", 9'h000, 0); rd_chk("R1", 9'h100, 0);
    rd_chk("R1", 9'h008, 0); rd_chk("R1", 9'h108, 0); rd_chk("R1", 9'h010, 0);
    chk("R1", {30'h0, irq, fiq}, 0);
    per_irq = '0;
    rst_n = 1'b1;
    settle();
    rd_chk("R1", 9'h004, 0);
    chk("R1", {30'h0, irq, fiq}, 0);
  endtask

  task automatic t_raw;
    per_irq = 24'hA5_0003; settle();
    rd_chk("R2", 9'h004, 32'h0294_000C);
    rd_chk("R2", 9'h104, 32'h0294_000C);
    per_irq = 24'h80_0000; settle();
    rd_chk("R2", 9'h004, 32'h0200_0000);
    rd_chk("R4", 9'h000, 0);
    chk("R2", {30'h0, irq, fiq}, 0);
    per_irq = '0; settle();
    rd_chk("R2", 9'h004, 0);
  endtask

  task automatic t_swi;
    wr_reg(9'h010, 32'h2);
    rd_chk("R3", 9'h010, 32'h2);
    rd_chk("R3", 9'h004, 32'h2);
    rd_chk("R3", 9'h104, 32'h2);
    wr_reg(9'h010, 32'hFFFF_FFFD);
    rd_chk("R3", 9'h004, 0);
  endtask

  task automatic t_mask_irq;
    wr_reg(9'h008, 32'hFFFF_FFFF);
    rd_chk("R6", 9'h008, 32'h03FF_FFFE);
    wr_reg(9'h00C, 32'hFFFF_FFFF);
    wr_reg(9'h008, 32'h0000_0010);
    wr_reg(9'h008, 32'h0000_0100);
    rd_chk("R6", 9'h008, 32'h0000_0110);
    per_irq = 24'h00_0044; settle();
    rd_chk("R4", 9'h000, 32'h0000_0110);
    rd_chk("R4", 9'h004, 32'h0000_0110);
    per_irq = 24'h00_0004;
    settle();
    chk("R8", {31'h0, irq}, 1);
    per_irq = 24'h0; #0.5;
    chk("R8", {31'h0, irq}, 1);
    settle();
    chk("R8", {31'h0, irq}, 0);
    wr_reg(9'h00C, 32'h0000_0010);
    rd_chk("R7", 9'h008, 32'h0000_0100);
    per_irq = 24'h00_0004; settle(); settle();
    chk("R7", {31'h0, irq}, 0);
    per_irq = 24'h00_0040; #0.5;
    chk("R8", {31'h0, irq}, 0);
    settle();
    chk("R8", {31'h0, irq}, 1);
    per_irq = '0; settle();
    wr_reg(9'h00C, 32'hFFFF_FFFF);
    rd_chk("R7", 9'h008, 0);
  endtask

  task automatic t_fiq;
    rd_chk("R5", 9'h100, 0);
    per_irq = 24'h80_0000;
    wr_reg(9'h108, 32'h0200_0000);
    chk("R8", {31'h0, fiq}, 0);
    rd_chk("R5", 9'h100, 32'h0200_0001);
    settle();
    chk("R8", {31'h0, fiq}, 1);
    chk("R9", {31'h0, irq}, 0);
    wr_reg(9'h10C, 32'h0200_0000);
    rd_chk("R7", 9'h100, 0);
    settle();
    chk("R8", {31'h0, fiq}, 0);
    per_irq = '0;
  endtask

  task automatic t_both;
    wr_reg(9'h008, 32'h0000_0002);
    wr_reg(9'h108, 32'h0000_0002);
    wr_reg(9'h010, 32'h2);
    rd_chk("R9", 9'h000, 32'h2);
    rd_chk("R9", 9'h100, 32'h3);
    settle();
    chk("R9", {30'h0, irq, fiq}, 2'b11);
    wr_reg(9'h10C, 32'h0000_0002);
    rd_chk("R9", 9'h008, 32'h2);
    settle();
    chk("R9", {30'h0, irq, fiq}, 2'b10);
    wr_reg(9'h00C, 32'h0000_0002);
    wr_reg(9'h010, 32'h0);
  endtask

  task automatic t_ro;
    wr_reg(9'h008, 32'h0000_0400);
    wr_reg(9'h000, 32'hFFFF_FFFF);
    wr_reg(9'h004, 32'hFFFF_FFFF);
    wr_reg(9'h100, 32'hFFFF_FFFF);
    wr_reg(9'h104, 32'hFFFF_FFFF);
    rd_chk("R10", 9'h008, 32'h0000_0400);
    rd_chk("R10", 9'h108, 0);
    rd_chk("R10", 9'h004, 0);
    rd_chk("R10", 9'h010, 0);
    settle();
    chk("R10", {30'h0, irq, fiq}, 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_raw(); t_swi(); t_mask_irq(); t_fiq(); t_both(); t_ro();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule